// File: doc/BRIEF.md
# Watchdog Down-Counter with Keyed Restart

This block is a watchdog timer with a register interface. It counts down from a programmed reload value, at either a 1 µs tick rate or the bus clock rate. When a counting step finds the count already at zero, the block raises a one-cycle expiry strobe and reloads the count. The expiry strobe is forwarded as a reset request and as an external signal request, each gated by its own control bit. The control register also carries a reset-scope code, which is driven straight out to the reset logic.

Software keeps the watchdog from expiring by writing a fixed 16-bit key to the restart register. A write of any other value to that register does nothing. The upper 22 bits of the control register hold a pre-timeout threshold. When the count steps into the 1024-count region whose upper bits equal that threshold, a sticky pending flag is set. The flag drives the interrupt output, and software clears it through a separate clear register.

The register bus is always ready. A write is taken in any cycle where `bus_wen` is high, and there is no back-pressure. Reads are combinational from `bus_addr`.

Top module: `wdg_top`

## Requirements
- R1: After reset, the count and reload registers both hold the parameter RELOAD_RST, the control register is 0, the pending flag is 0, and all request outputs are low.
- R2: The byte offset is decoded from `bus_addr[4:2]` as follows. 0x00 reads the count, 0x04 reads and writes the reload value, 0x0C reads and writes control, and 0x10 reads the pending flag at bit 2. The restart (0x08) and clear (0x14) registers read 0, as do unused offsets. Writes to 0x00 and 0x10 are ignored. Control bits 9:7 always read 0.
- R3: A write of exactly 0x0000_4755 to offset 0x08 loads the reload register's old value into the count at the next edge. Any other value written there leaves the count unchanged.
- R4: The count changes only when control bit 0 is 1. Each step lowers it by one.
- R5: When control bit 4 is 1, a step occurs only in cycles where `tick` is high. When bit 4 is 0, a step occurs every clock cycle.
- R6: A step taken while the count is 0 reloads the count from the reload register. In the following cycle, `expire` is high for exactly that one cycle.
- R7: `rst_req` equals `expire` AND control bit 1. `ext_req` equals `expire` AND control bit 3. `rst_scope` always shows control bits 6:5, where 00 is SoC, 01 is whole chip and 10 is CPU only.
- R8: When control bit 2 is 1 and a step moves the count into the region whose bits 31:10 equal control bits 31:10 (coming from outside that region), the pending flag sets at the next edge. `irq` shows the flag.
- R9: A write to offset 0x14 with bit 0 set clears the pending flag. If a set and a clear happen in the same cycle, the set wins. Otherwise the flag holds its value.
- R10: A key write to the restart register takes priority over a step in the same cycle. In that case no expiry and no pre-timeout entry occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 1 µs time-base enable pulse |
| bus_wen | input | 1 | Write strobe, taken every cycle it is high |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| expire | output | 1 | One-cycle expiry strobe |
| rst_req | output | 1 | Reset request |
| ext_req | output | 1 | External signal request |
| rst_scope | output | 2 | Reset scope code |
| irq | output | 1 | Pre-timeout interrupt |

## Verification
The assertions assume that `bus_wdata` and `bus_addr` are known whenever `bus_wen` is high, and that `rst_n` is held low long enough to reach the first clock edge. The bench drives every input on the falling edge and holds it for a full cycle. It asserts `bus_wen` for one cycle per write, and it never drives an unknown value. Where the priority rules interact, the stimulus pushes into them on purpose: key writes land in the middle of counting, and clears are issued while the count is still inside the threshold region.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // register index = byte offset >> 2
  localparam logic [2:0] IDX_COUNT   = 3'd0;
  localparam logic [2:0] IDX_RELOAD  = 3'd1;
  localparam logic [2:0] IDX_RESTART = 3'd2;
  localparam logic [2:0] IDX_CTRL    = 3'd3;
  localparam logic [2:0] IDX_STATUS  = 3'd4;
  localparam logic [2:0] IDX_CLEAR   = 3'd5;

  localparam logic [15:0] RESTART_KEY = 16'h4755;

  // control bit positions
  localparam int B_EN     = 0;
  localparam int B_RSTEN  = 1;
  localparam int B_IRQEN  = 2;
  localparam int B_EXTEN  = 3;
  localparam int B_TBSEL  = 4;
  localparam int B_SCOPE  = 5;
  localparam int THR_LSB  = 10;
  localparam int FLAG_BIT = 2;

  typedef enum logic [1:0] {
    SCOPE_SOC  = 2'b00,
    SCOPE_CHIP = 2'b01,
    SCOPE_CPU  = 2'b10,
    SCOPE_RSVD = 2'b11
  } scope_e;
endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
  import wdg_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter logic [DW-1:0] RELOAD_RST = 32'h0000_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count_i,
  input  logic          flag_i,
  output logic [DW-1:0] reload_o,
  output logic [DW-1:0] ctrl_o,
  output logic          key_hit_o,
  output logic          clr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int LOW_W = THR_LSB - 7;
  localparam logic [DW-1:0] CTRL_MASK = {{(DW-THR_LSB){1'b1}}, {LOW_W{1'b0}}, 7'h7F};
  localparam logic [DW-1:0] KEY_FULL  = DW'(RESTART_KEY);

  logic [2:0]    idx;
  logic [DW-1:0] reload_q, ctrl_q;

  assign idx       = addr[4:2];
  assign key_hit_o = wen && (idx == IDX_RESTART) && (wdata == KEY_FULL);
  assign clr_o     = wen && (idx == IDX_CLEAR) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      ctrl_q   <= '0;
    end else if (wen) begin
      if (idx == IDX_RELOAD) reload_q <= wdata;
      if (idx == IDX_CTRL)   ctrl_q   <= wdata & CTRL_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_COUNT:  rdata_o = count_i;
      IDX_RELOAD: rdata_o = reload_q;
      IDX_CTRL:   rdata_o = ctrl_q;
      IDX_STATUS: rdata_o[FLAG_BIT] = flag_i;
      default:    rdata_o = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
  parameter int DW = 32,
  parameter logic [DW-1:0] RELOAD_RST = 32'h0000_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tb_sel,
  input  logic          tick,
  input  logic          restart,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] count_nxt_o,
  output logic          stepped_o,
  output logic          expire_o
);
  logic [DW-1:0] count_q, count_n;
  logic          step, at_zero, expire_q;

  assign step      = en && (tb_sel ? tick : 1'b1);
  assign at_zero   = (count_q == '0);
  assign stepped_o = step && !restart;

  always_comb begin
    count_n = count_q;
    if (restart)        count_n = reload;
    else if (step)      count_n = at_zero ? reload : count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= RELOAD_RST;
      expire_q <= 1'b0;
    end else begin
      count_q  <= count_n;
      expire_q <= stepped_o && at_zero;
    end
  end

  assign count_o     = count_q;
  assign count_nxt_o = count_n;
  assign expire_o    = expire_q;
endmodule

// File: rtl/wdg_pretimeout.sv
module wdg_pretimeout #(
  parameter int DW  = 32,
  parameter int LSB = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_en,
  input  logic             stepped,
  input  logic [DW-1:0]    cur,
  input  logic [DW-1:0]    nxt,
  input  logic [DW-LSB-1:0] thr,
  input  logic             clr,
  output logic             flag_o
);
  logic flag_q, enter;

  assign enter = irq_en && stepped &&
                 (nxt[DW-1:LSB] == thr) && (cur[DW-1:LSB] != thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (enter)  flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter logic [DW-1:0] RELOAD_RST = 32'h0000_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wen,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          expire,
  output logic          rst_req,
  output logic          ext_req,
  output logic [1:0]    rst_scope,
  output logic          irq
);
  logic [DW-1:0] reload, ctrl, count, count_nxt;
  logic          key_hit, clr, flag, stepped;

  wdg_regfile #(.DW(DW), .AW(AW), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
    .count_i(count), .flag_i(flag), .reload_o(reload), .ctrl_o(ctrl),
    .key_hit_o(key_hit), .clr_o(clr), .rdata_o(bus_rdata)
  );

  wdg_down_counter #(.DW(DW), .RELOAD_RST(RELOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl[B_EN]), .tb_sel(ctrl[B_TBSEL]), .tick(tick),
    .restart(key_hit), .reload(reload), .count_o(count), .count_nxt_o(count_nxt),
    .stepped_o(stepped), .expire_o(expire)
  );

  wdg_pretimeout #(.DW(DW), .LSB(THR_LSB)) u_pre (
    .clk(clk), .rst_n(rst_n), .irq_en(ctrl[B_IRQEN]), .stepped(stepped),
    .cur(count), .nxt(count_nxt), .thr(ctrl[DW-1:THR_LSB]), .clr(clr), .flag_o(flag)
  );

  assign rst_req   = expire && ctrl[B_RSTEN];
  assign ext_req   = expire && ctrl[B_EXTEN];
  assign rst_scope = ctrl[B_SCOPE+1:B_SCOPE];
  assign irq       = flag;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wen,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] count,
  input logic [DW-1:0] reload,
  input logic [DW-1:0] ctrl,
  input logic          clr,
  input logic          expire,
  input logic          rst_req,
  input logic          ext_req,
  input logic          irq
);
  logic key_wr;
  assign key_wr = bus_wen && (bus_addr[4:2] == IDX_RESTART) &&
                  (bus_wdata == DW'(RESTART_KEY));

  AST_RST_ONLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> expire); // R7
  AST_EXT_ONLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> expire); // R7
  AST_KEY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (count == $past(reload))); // R3
  AST_EXPIRY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (count == $past(reload))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_EN] && !key_wr) |=> $stable(count)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq); // R9
endmodule

bind wdg_top wdg_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .count(count), .reload(reload), .ctrl(ctrl), .clr(clr),
  .expire(expire), .rst_req(rst_req), .ext_req(ext_req), .irq(irq)
);

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_VAL = 32'h0000_0FFF;

  logic        clk = 0, rst_n = 0, tick = 0, bus_wen = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        expire, rst_req, ext_req, irq;
  logic [1:0]  rst_scope;

  int n_vec = 0, n_bad = 0, cyc = 0, tcnt = 0;
  string tag = "R1";

  wdg_top #(.DW(32), .AW(5), .RELOAD_RST(RST_VAL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire), .rst_req(rst_req),
    .ext_req(ext_req), .rst_scope(rst_scope), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_cnt, m_rel, m_ctrl;
  logic        m_flag, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = RST_VAL; m_rel = RST_VAL; m_ctrl = 0; m_flag = 0; m_exp = 0;
    end else begin
      automatic int idx = int'(bus_addr[4:2]);
      automatic bit key = bus_wen && idx == 2 && bus_wdata == 32'h0000_4755;
      automatic bit stp = m_ctrl[0] && (m_ctrl[4] ? tick : 1'b1);
      automatic bit clr = bus_wen && idx == 5 && bus_wdata[0];
      automatic logic [31:0] old = m_cnt;
      automatic logic [31:0] nw = m_cnt;
      automatic bit ent;
      if (key) nw = m_rel;
      else if (stp) nw = (old == 0) ? m_rel : old - 1;
      ent = m_ctrl[2] && stp && !key && (nw[31:10] == m_ctrl[31:10]) &&
            (old[31:10] != m_ctrl[31:10]);
      m_exp  = stp && !key && (old == 0);
      m_flag = ent ? 1'b1 : (clr ? 1'b0 : m_flag);
      m_cnt  = nw;
      if (bus_wen && idx == 1) m_rel = bus_wdata;
      if (bus_wen && idx == 3) m_ctrl = bus_wdata & 32'hFFFF_FC7F;
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    case (int'(bus_addr[4:2]))
      0: return m_cnt;
      1: return m_rel;
      3: return m_ctrl;
      4: return {29'b0, m_flag, 2'b0};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    chk(tag, "rdata", bus_rdata, exp_rd());
    chk(tag, "expire", {31'b0, expire}, {31'b0, m_exp});
    chk(tag, "rst_req", {31'b0, rst_req}, {31'b0, m_exp & m_ctrl[1]});
    chk(tag, "ext_req", {31'b0, ext_req}, {31'b0, m_exp & m_ctrl[3]});
    chk(tag, "scope", {30'b0, rst_scope}, {30'b0, m_ctrl[6:5]});
    chk(tag, "irq", {31'b0, irq}, {31'b0, m_flag});
  end

  always @(negedge clk) begin
    tick <= (tcnt % 4 == 3);
    tcnt <= tcnt + 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog timeout actual=%0d expected<=%0d", cyc, 50000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd_at(input logic [4:0] a);
    @(negedge clk);
    bus_addr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rst_n = 1;
    rd_at(5'h04); #1; chk("R1", "reload after reset", bus_rdata, RST_VAL);
    rd_at(5'h00); #1; chk("R1", "count after reset", bus_rdata, RST_VAL);

    tag = "R2";
    for (int a = 0; a < 8; a++) rd_at(5'(a * 4));
    wr(5'h00, 32'h1234_5678);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h0000_0380);
    rd_at(5'h0C); #1; chk("R2", "ctrl reserved bits", bus_rdata, 32'h0);

    tag = "R3";
    wr(5'h04, 32'd20);
    wr(5'h08, 32'h0000_4756);
    rd_at(5'h00); #1; chk("R3", "count after wrong key", bus_rdata, RST_VAL);
    wr(5'h08, 32'h0001_4755);
    wr(5'h08, 32'h0000_4755);
    rd_at(5'h00); #1; chk("R3", "count after key", bus_rdata, 32'd20);

    tag = "R4";
    wr(5'h0C, 32'h0000_0001);
    idle(15);
    tag = "R6";
    idle(30);

    tag = "R5";
    wr(5'h0C, 32'h0000_0011);
    idle(120);

    tag = "R7";
    wr(5'h04, 32'd3);
    wr(5'h0C, 32'h0000_006B);
    wr(5'h08, 32'h0000_4755);
    idle(20);
    wr(5'h0C, 32'h0000_0043);
    idle(12);
    wr(5'h0C, 32'h0000_0029);
    idle(12);

    tag = "R8";
    wr(5'h0C, 32'h0000_0000);
    wr(5'h04, 32'd2060);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h0000_0405);
    rd_at(5'h10);
    idle(25);
    #1; chk("R8", "flag after threshold entry", bus_rdata, 32'h4);

    tag = "R9";
    wr(5'h14, 32'h0000_0002);
    idle(2);
    wr(5'h14, 32'h0000_0001);
    rd_at(5'h10); #1; chk("R9", "flag after clear", bus_rdata, 32'h0);
    idle(10);

    tag = "R10";
    wr(5'h04, 32'd2);
    wr(5'h0C, 32'h0000_0003);
    for (int k = 0; k < 6; k++) begin
      wr(5'h08, 32'h0000_4755);
      idle(k);
    end
    rd_at(5'h00);
    idle(10);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule